// File: doc/BRIEF.md
# Prescaled Capture/PWM General Timer

A 32-bit up-counting timer for general event timing. The counter advances on a strobe taken either from a power-of-two clock prescaler or from a fractional divider. The fractional divider turns a 32.768 kHz functional clock into an exact 1 ms average tick by mixing 32-cycle and 33-cycle periods. When the counter overflows it reloads from a load register. In one-shot mode it also stops itself.

A compare register drives a dedicated timer output. The output either produces a PWM waveform (set on a match, cleared on overflow) or emits one-cycle trigger pulses on counter events. A dedicated trigger input is synchronised, and its selected edge latches the running count into a capture register. A general-purpose output bit follows a control-register field.

Software reaches all of this through a flat word-addressed register port with same-cycle reads. The counter can be rewritten while it runs without stopping the timer.

Top module: `gpt_timer`

## Requirements
- R1: After reset, every register reads 0, and timer_o, gpo_o and tick_o are low.
- R2: With CTRL[11]=0, the counter advances once per 2^n clocks, where n is CTRL[5:2]; a field value above 8 acts as 8. tick_o pulses for one cycle on each advance, and the first advance comes 2^n clocks after the enabling write.
- R3: With CTRL[1]=1 (auto-reload), an advance from 0xFFFFFFFF loads the LOAD register value and counting continues.
- R4: With CTRL[1]=0 (one-shot), an advance from 0xFFFFFFFF loads the LOAD value and clears the enable bit CTRL[0].
- R5: A COUNT write while CTRL[0]=1 does not change the count until the next advance, which takes the written value in place of the increment. While stopped, a COUNT write takes effect at once.
- R6: With CTRL[9]=1 (PWM) and CTRL[10]=1 (compare enabled), timer_o rises on an advance from a count equal to MATCH and falls on an overflow advance. Each change is registered one clock after the advance.
- R7: With CTRL[9]=0 (trigger), timer_o is a one-cycle pulse following each overflow advance and, when CTRL[10]=1, each match advance.
- R8: With CTRL[6]=1, the edge of trig_i selected by CTRL[8:7] (01 rising, 10 falling, 11 both, 00 none) copies COUNT into CAPTURE. The input passes a two-flop synchroniser first. With CTRL[6]=0, CAPTURE holds.
- R9: gpo_o equals CTRL[12], one clock after the write.
- R10: With CTRL[11]=1, the prescaler field is ignored and the advance periods are 32 or 33 clocks. The first period is 32 and the second is 33, and 1000 advances take exactly 32768 clocks from the enabling write.
- R11: The register map is word addressed, with reads valid in the same cycle: 0 CTRL, 1 COUNT, 2 LOAD, 3 MATCH, 4 CAPTURE (read-only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| trig_i | input | 1 | Capture trigger input, asynchronous |
| timer_o | output | 1 | PWM or trigger-pulse output |
| gpo_o | output | 1 | General-purpose output bit |
| tick_o | output | 1 | One-cycle strobe on every counter advance |

## Verification
The hardest case to reach is the long-run exactness of the fractional tick. A single 32 or 33 cycle period says little about it; it only shows once a full 1000-advance cycle of the accumulator has closed. The bench therefore enables tick mode from a zero count and checks the first two periods for their lengths. It then checks the count one clock before and at clock 32768. The deferred counter write is reached by writing COUNT partway through an 8-clock prescaler period and sampling on both sides of the next advance.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MATCH = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;

  localparam int CTRL_W   = 13;
  localparam int B_EN     = 0;
  localparam int B_AR     = 1;
  localparam int B_PS     = 2;
  localparam int PS_W     = 4;
  localparam int B_CAP_EN = 6;
  localparam int B_EDGE   = 7;
  localparam int B_PWM    = 9;
  localparam int B_CMP    = 10;
  localparam int B_TICKM  = 11;
  localparam int B_GPO    = 12;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } cap_edge_e;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PS_MAX = 8,
  parameter int PS_W   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PS_W-1:0] n_i,
  output logic            tick_o
);
  localparam logic [PS_W-1:0] N_CAP = PS_W'(PS_MAX);

  logic [PS_MAX-1:0] cnt_q;
  logic [PS_W-1:0]   n_eff;
  logic [PS_MAX-1:0] mask;

  always_comb begin
    n_eff  = (n_i > N_CAP) ? N_CAP : n_i;
    mask   = ~({PS_MAX{1'b1}} << n_eff);
    tick_o = run_i && ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gpt_frac_tick.sv
module gpt_frac_tick #(
  parameter int BASE = 32,
  parameter int NUM  = 768,
  parameter int DEN  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CYC_W = $clog2(BASE + 1);
  localparam int ACC_W = $clog2(DEN);

  logic [CYC_W-1:0] cyc_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             long_p;
  logic [CYC_W-1:0] last;

  always_comb begin
    // period is one longer when this step carries out of the accumulator
    long_p = acc_q >= ACC_W'(DEN - NUM);
    last   = long_p ? CYC_W'(BASE) : CYC_W'(BASE - 1);
    tick_o = run_i && (cyc_q == last);
    sum    = {1'b0, acc_q} + (ACC_W + 1)'(NUM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      acc_q <= '0;
    end else if (!run_i) begin
      cyc_q <= '0;
      acc_q <= '0;
    end else if (tick_o) begin
      cyc_q <= '0;
      acc_q <= (sum >= (ACC_W + 1)'(DEN)) ? ACC_W'(sum - (ACC_W + 1)'(DEN)) : sum[ACC_W-1:0];
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         reload_i,
  input  logic [W-1:0] load_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         stop_o,
  output logic         pend_o
);
  logic [W-1:0] cnt_q, pend_d_q;
  logic         pend_q;

  always_comb begin
    ovf_o  = tick_i && !pend_q && (cnt_q == {W{1'b1}});
    stop_o = ovf_o && !reload_i;
    cnt_o  = cnt_q;
    pend_o = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      pend_d_q <= '0;
      pend_q   <= 1'b0;
    end else if (!run_i) begin
      if (wr_i)        cnt_q <= wr_data_i;
      else if (pend_q) cnt_q <= pend_d_q;
      pend_q <= 1'b0;
    end else begin
      if (tick_i) begin
        if (pend_q)      cnt_q <= pend_d_q;
        else if (ovf_o)  cnt_q <= load_i;
        else             cnt_q <= cnt_q + 1'b1;
      end
      if (wr_i) begin
        pend_q   <= 1'b1;
        pend_d_q <= wr_data_i;
      end else if (tick_i) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trig_i,
  input  logic         en_i,
  input  logic [1:0]   edge_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o
);
  import gpt_pkg::*;

  logic [2:0]   sync_q;
  logic         rise, fall, hit;
  cap_edge_e    sel;
  logic [W-1:0] cap_q;

  always_comb begin
    sel  = cap_edge_e'(edge_i);
    rise = sync_q[1] && !sync_q[2];
    fall = !sync_q[1] && sync_q[2];
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise || fall;
      default:   hit = 1'b0;
    endcase
    cap_o = cap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cap_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], trig_i};
      if (en_i && hit) cap_q <= cnt_i;
    end
  end
endmodule

// File: rtl/gpt_out.sv
module gpt_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic ovf_i,
  input  logic match_i,
  output logic out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_o <= 1'b0;
    else if (pwm_i) begin
      if (ovf_i)        out_o <= 1'b0;
      else if (match_i) out_o <= 1'b1;
    end else begin
      out_o <= ovf_i || match_i;
    end
  end
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int PS_MAX    = 8,
  parameter int TICK_BASE = 32,
  parameter int TICK_NUM  = 768,
  parameter int TICK_DEN  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              trig_i,
  output logic              timer_o,
  output logic              gpo_o,
  output logic              tick_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] load_q, match_q, cnt_q, cap_q;
  logic pre_tick, frac_tick, tick, ovf, stop, pend, match_evt;
  logic run, tick_mode;

  assign run       = ctrl_q[B_EN];
  assign tick_mode = ctrl_q[B_TICKM];

  gpt_prescaler #(.PS_MAX(PS_MAX), .PS_W(PS_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run && !tick_mode),
    .n_i(ctrl_q[B_PS +: PS_W]), .tick_o(pre_tick)
  );

  gpt_frac_tick #(.BASE(TICK_BASE), .NUM(TICK_NUM), .DEN(TICK_DEN)) u_frac (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run && tick_mode), .tick_o(frac_tick)
  );

  assign tick = tick_mode ? frac_tick : pre_tick;

  gpt_counter #(.W(DATA_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(tick),
    .reload_i(ctrl_q[B_AR]), .load_i(load_q),
    .wr_i(we_i && addr_i == A_COUNT), .wr_data_i(wdata_i),
    .cnt_o(cnt_q), .ovf_o(ovf), .stop_o(stop), .pend_o(pend)
  );

  assign match_evt = tick && ctrl_q[B_CMP] && (cnt_q == match_q);

  gpt_out u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(ctrl_q[B_PWM]),
    .ovf_i(ovf), .match_i(match_evt), .out_o(timer_o)
  );

  gpt_capture #(.W(DATA_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i),
    .en_i(ctrl_q[B_CAP_EN]), .edge_i(ctrl_q[B_EDGE +: 2]),
    .cnt_i(cnt_q), .cap_o(cap_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      else if (stop)                ctrl_q[B_EN] <= 1'b0;
      if (we_i && addr_i == A_LOAD)  load_q  <= wdata_i;
      if (we_i && addr_i == A_MATCH) match_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {{(DATA_W - CTRL_W){1'b0}}, ctrl_q};
      A_COUNT: rdata_o = cnt_q;
      A_LOAD:  rdata_o = load_q;
      A_MATCH: rdata_o = match_q;
      A_CAPT:  rdata_o = cap_q;
      default: rdata_o = '0;
    endcase
  end

  assign gpo_o  = ctrl_q[B_GPO];
  assign tick_o = tick;
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk
  import gpt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              gpo_o,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] cap_q,
  input logic              pend,
  input logic              pre_tick,
  input logic              frac_tick
);
  // R9
  gpo_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL) |=> (gpo_o == $past(wdata_i[B_GPO])));

  // R5
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[B_EN] && !we_i && !pend) |=> $stable(cnt_q));

  // R8
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[B_CAP_EN] |=> $stable(cap_q));

  // R2
  prescale_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_tick && ctrl_q[B_PS +: PS_W] != '0 && !we_i) |=> !pre_tick);

  // R10
  frac_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_tick |=> !frac_tick);
endmodule

bind gpt_timer gpt_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .gpo_o(gpo_o), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .cap_q(cap_q), .pend(pend),
  .pre_tick(pre_tick), .frac_tick(frac_tick)
);

// File: tb/gpt_timer_tb.sv
module gpt_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        trig_i = 1'b0;
  logic        timer_o, gpo_o, tick_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  gpt_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .trig_i(trig_i), .timer_o(timer_o), .gpo_o(gpo_o), .tick_o(tick_o)
  );

  typedef struct packed {
    logic [3:0]  ps;
    logic        ar;
    logic [31:0] start;
    logic [31:0] load;
    logic [15:0] wt;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 32'd0,          32'd0,    16'd10,  32'd10},
    '{4'd1,  1'b0, 32'd5,          32'd0,    16'd10,  32'd10},
    '{4'd3,  1'b0, 32'd100,        32'd0,    16'd40,  32'd105},
    '{4'd8,  1'b0, 32'd0,          32'd0,    16'd600, 32'd2},
    '{4'd0,  1'b1, 32'hFFFF_FFFE,  32'h10,   16'd4,   32'h12},
    '{4'd2,  1'b0, 32'd7,          32'd0,    16'd13,  32'd10},
    '{4'd12, 1'b0, 32'd0,          32'd0,    16'd520, 32'd2}
  };

  function automatic logic [31:0] mk(input logic en, ar, input logic [3:0] ps,
                                     input logic cap, input logic [1:0] edg,
                                     input logic pwm, cmp, tm, gpo);
    return {19'd0, gpo, tm, cmp, pwm, edg, cap, ps, ar, en};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 count", v, 0);
    rd(3'd4, v); chk("R1 capture", v, 0);
    chk("R1 outputs", {29'd0, timer_o, gpo_o, tick_o}, 0);

    // R2 / R3 table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 0);
      wr(3'd2, VECS[i].load);
      wr(3'd1, VECS[i].start);
      wr(3'd0, mk(1'b1, VECS[i].ar, VECS[i].ps, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
      repeat (int'(VECS[i].wt)) @(negedge clk_i);
      rd(3'd1, v);
      chk(VECS[i].ar ? "R3 reload vector" : "R2 prescale vector", v, VECS[i].exp);
    end

    // R11 register readback
    wr(3'd0, 0);
    wr(3'd3, 32'h5A5A_0001);
    wr(3'd2, 32'h0000_BEEF);
    rd(3'd3, v); chk("R11 match readback", v, 32'h5A5A_0001);
    rd(3'd2, v); chk("R11 load readback", v, 32'h0000_BEEF);

    // R4 one-shot
    wr(3'd2, 32'h33);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, mk(1'b1, 1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (5) @(negedge clk_i);
    rd(3'd1, v); chk("R4 one-shot count", v, 32'h33);
    rd(3'd0, v); chk("R4 enable cleared", {31'd0, v[0]}, 0);

    // R5 deferred write while running
    wr(3'd0, 0);
    wr(3'd1, 0);
    wr(3'd0, mk(1'b1, 1'b0, 4'd3, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk_i);
    wr(3'd1, 32'h1000);
    rd(3'd1, v); chk("R5 write deferred", v, 0);
    repeat (6) @(negedge clk_i);
    rd(3'd1, v); chk("R5 write applied at tick", v, 32'h1000);
    repeat (8) @(negedge clk_i);
    rd(3'd1, v); chk("R5 counting resumes", v, 32'h1001);

    // R6 PWM duty
    wr(3'd0, 0);
    wr(3'd2, 32'hFFFF_FFF0);
    wr(3'd3, 32'hFFFF_FFF8);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd0, mk(1'b1, 1'b1, 4'd0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0));
    hi = 0;
    for (int k = 0; k < 160; k++) begin
      @(negedge clk_i);
      if (timer_o) hi++;
    end
    chk("R6 pwm high cycles", hi, 70);

    // R7 trigger pulses
    wr(3'd0, 0);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd0, mk(1'b1, 1'b1, 4'd0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0));
    hi = 0;
    for (int k = 0; k < 160; k++) begin
      @(negedge clk_i);
      if (timer_o) hi++;
    end
    chk("R7 trigger pulse cycles", hi, 20);

    // R8 capture
    wr(3'd0, 0);
    wr(3'd1, 32'hABCD);
    wr(3'd0, mk(1'b0, 1'b0, 4'd0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0));
    trig_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(3'd4, v); chk("R8 rising capture", v, 32'hABCD);
    wr(3'd1, 32'h1234);
    trig_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rd(3'd4, v); chk("R8 falling ignored in rising mode", v, 32'hABCD);
    wr(3'd0, mk(1'b0, 1'b0, 4'd0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0));
    trig_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(3'd4, v); chk("R8 rising ignored in falling mode", v, 32'hABCD);
    trig_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rd(3'd4, v); chk("R8 falling capture", v, 32'h1234);
    wr(3'd0, mk(1'b0, 1'b0, 4'd0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(3'd1, 32'h9);
    trig_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(3'd4, v); chk("R8 capture disabled", v, 32'h1234);
    trig_i = 1'b0;

    // R9 gpo
    wr(3'd0, mk(1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1));
    chk("R9 gpo set", {31'd0, gpo_o}, 1);
    wr(3'd0, 0);
    chk("R9 gpo clear", {31'd0, gpo_o}, 0);

    // R10 fractional 1 ms tick
    wr(3'd1, 0);
    wr(3'd0, mk(1'b1, 1'b0, 4'd5, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0));
    repeat (31) @(negedge clk_i);
    rd(3'd1, v); chk("R10 before first tick", v, 0);
    @(negedge clk_i);
    rd(3'd1, v); chk("R10 first period 32", v, 1);
    repeat (32) @(negedge clk_i);
    rd(3'd1, v); chk("R10 second period not 32", v, 1);
    @(negedge clk_i);
    rd(3'd1, v); chk("R10 second period 33", v, 2);
    repeat (32767 - 65) @(negedge clk_i);
    rd(3'd1, v); chk("R10 one clock before 32768", v, 999);
    @(negedge clk_i);
    rd(3'd1, v); chk("R10 1000 ticks in 32768", v, 1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule